// File: doc/BRIEF.md
# Bit-Slip Serial-to-Parallel Deserializer

This block gathers a one-bit serial stream, sampled on every edge of a bit-rate clock, into parallel words. By default a word is 4 bits wide. The serial bit comes from one of two inputs. The second input lets a link be looped back on itself for test without the external medium. The block also produces two slow clocks. One runs at the word rate and one at twice the word period. Downstream logic uses them to pick up each word.

A framing-width control chooses how often the word register reloads: once per word, or once per two words. Reloading every two words lets two instances form a 1:8 converter. The first instance passes its delayed serial stream to the second, and both run from the same clock. An asynchronous slip request moves the word boundary by one bit. Each request is synchronised and reduced to a single edge event. That event makes the internal counter skip one clock, so word framing can be searched bit by bit. A synchronous reset puts the counter in a known phase, so several instances start aligned.

Top module: `bitslip_deser`

## Requirements
- R1: Within each word, the earliest sampled bit appears on `par_q[0]`, and each later bit appears one position higher, up to `par_q[3]`.
- R2: The sampled bit is `ser_a` when `src_sel` is 1 and `ser_b` when `src_sel` is 0.
- R3: With `wide_mode` at 0, `par_q` loads on every 4th non-skipped edge. The load takes the bit sampled on that edge and the three before it. The first word after reset is loaded on the 4th edge after reset is released.
- R4: With `wide_mode` at 1, `par_q` loads only on every 8th non-skipped edge. It holds the bits of non-skipped phases 4 to 7. The first word is loaded on the 8th edge after reset is released.
- R5: Between loads, `par_q` holds its value.
- R6: Both slow clocks start low after reset. `word_clk` is bit 1 of the phase count: a low half of 2 edges, then a high half of 2 edges. `pair_clk` is bit 2 of the phase count and changes only where `word_clk` falls.
- R7: Suppose `slip_async` is first sampled high on edge E after being sampled low. Then edge E+2 is skipped: the phase count, both slow clocks and `par_q` stay unchanged on that edge, while serial sampling continues. A bit that would have landed on Qn then lands on Qn-1.
- R8: Holding `slip_async` high for any length of time causes one skip only. A further skip needs the input to be sampled low and then high again.
- R9: An active-high synchronous `rst` clears the phase count, the shift stages, `par_q` and the slip history.
- R10: After each edge, `ser_thru` carries the bit sampled three edges earlier. A second instance sampling it therefore sees the stream delayed by one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 1 | Serial source choice: 1 = ser_a, 0 = ser_b |
| ser_a | input | 1 | Serial input A (loopback path) |
| ser_b | input | 1 | Serial input B (line path) |
| slip_async | input | 1 | Asynchronous bit-slip request |
| wide_mode | input | 1 | 0 = reload every word, 1 = reload every second word |
| par_q | output | 4 | Parallel word, bit 0 earliest |
| word_clk | output | 1 | Divide-by-4 clock |
| pair_clk | output | 1 | Divide-by-8 clock |
| ser_thru | output | 1 | Delayed serial stream for chaining |

## Verification
A pseudo-random stream is driven on `ser_a`, with its complement or an independent stream on `ser_b`. A swap between sources therefore shows up in every word, and a reversed bit order cannot match by chance. Three kinds of slip request are applied: short requests, two requests close together, and a long held level. These distinguish a correct single skip from no skip, from repeated skips, and from a skip on the wrong edge. Each kind is run in both framing widths. Runs from reset in both widths expose the first-word latency, and they show the zero state of the slow clocks.

// File: rtl/deser_pkg.sv
package deser_pkg;

  typedef enum logic {
    SRC_LINE = 1'b0,
    SRC_LOOP = 1'b1
  } src_e;

  // Picks the serial bit from the requested source.
  function automatic logic pick_src(input logic sel, input logic loop_bit, input logic line_bit);
    return (src_e'(sel) == SRC_LOOP) ? loop_bit : line_bit;
  endfunction

  // True when the phase count sits on the last phase of a frame.
  // Narrow framing ends each word; wide framing ends every second word.
  function automatic logic is_terminal(input int unsigned count, input int unsigned word_w,
                                       input logic wide);
    if (wide) return count == (2 * word_w - 1);
    return (count % word_w) == (word_w - 1);
  endfunction

endpackage

// File: rtl/deser_slip_sync.sv
module deser_slip_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic pulse
);
  // chain[0..STAGES-1] resynchronise; chain[STAGES] holds the previous level
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  always_comb pulse = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/deser_divider.sv
module deser_divider #(
  parameter int WORD_W = 4,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wide,
  input  logic             hold,
  output logic [CNT_W-1:0] count,
  output logic             at_term
);
  always_ff @(posedge clk) begin
    if (rst)        count <= '0;
    else if (!hold) count <= count + CNT_W'(1);
  end

  always_comb at_term = deser_pkg::is_terminal(int'(count), WORD_W, wide);
endmodule

// File: rtl/deser_shifter.sv
module deser_shifter #(
  parameter int WORD_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  output logic [WORD_W-1:0] stages,
  output logic [WORD_W-1:0] stages_nxt
);
  // New bits enter at the top; the oldest bit drifts to index 0.
  always_comb stages_nxt = {din, stages[WORD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) stages <= '0;
    else     stages <= stages_nxt;
  end
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int WORD_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_sel,
  input  logic              ser_a,
  input  logic              ser_b,
  input  logic              slip_async,
  input  logic              wide_mode,
  output logic [WORD_W-1:0] par_q,
  output logic              word_clk,
  output logic              pair_clk,
  output logic              ser_thru
);
  // WORD_W must be a power of two, at least 2.
  localparam int CNT_W = $clog2(2 * WORD_W);

  logic              din;
  logic              slip_pulse;
  logic              at_term;
  logic              word_load;
  logic [CNT_W-1:0]  phase;
  logic [WORD_W-1:0] stages;
  logic [WORD_W-1:0] stages_nxt;

  always_comb din = deser_pkg::pick_src(src_sel, ser_a, ser_b);

  deser_slip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (slip_async),
    .pulse    (slip_pulse)
  );

  deser_divider #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .wide    (wide_mode),
    .hold    (slip_pulse),
    .count   (phase),
    .at_term (at_term)
  );

  deser_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .din        (din),
    .stages     (stages),
    .stages_nxt (stages_nxt)
  );

  // A swallowed edge neither advances the phase nor loads a word.
  always_comb word_load = at_term & ~slip_pulse;

  always_ff @(posedge clk) begin
    if (rst)            par_q <= '0;
    else if (word_load) par_q <= stages_nxt;
  end

  always_comb begin
    word_clk = phase[CNT_W-2];
    pair_clk = phase[CNT_W-1];
    ser_thru = stages[0];
  end
endmodule

// File: rtl/deser_checker.sv
module deser_checker #(
  parameter int WORD_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wide_mode,
  input logic              slip_pulse,
  input logic              word_load,
  input logic [WORD_W-1:0] par_q,
  input logic              word_clk,
  input logic              pair_clk,
  input logic              ser_thru
);
  assert_slip_single_R8: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> !slip_pulse);

  assert_swallow_R7: assert property (@(posedge clk) disable iff (rst)
    slip_pulse |=> ($stable(word_clk) && $stable(pair_clk) && $stable(par_q)));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !word_load |=> $stable(par_q));

  assert_load_phase_narrow_R3: assert property (@(posedge clk) disable iff (rst)
    (word_load && !wide_mode) |-> word_clk);

  assert_load_phase_wide_R4: assert property (@(posedge clk) disable iff (rst)
    (word_load && wide_mode) |-> (word_clk && pair_clk));

  assert_thru_match_R10: assert property (@(posedge clk) disable iff (rst)
    word_load |=> (par_q[0] == ser_thru));

  assert_pair_step_R6: assert property (@(posedge clk) disable iff (rst)
    (pair_clk != $past(pair_clk)) |-> $fell(word_clk));
endmodule

bind bitslip_deser deser_checker #(.WORD_W(WORD_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wide_mode  (wide_mode),
  .slip_pulse (slip_pulse),
  .word_load  (word_load),
  .par_q      (par_q),
  .word_clk   (word_clk),
  .pair_clk   (pair_clk),
  .ser_thru   (ser_thru)
);

// File: tb/bitslip_deser_tb.sv
module bitslip_deser_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       src_sel = 1'b1;
  logic       ser_a = 1'b0;
  logic       ser_b = 1'b0;
  logic       slip_async = 1'b0;
  logic       wide_mode = 1'b0;
  logic [3:0] par_q;
  logic       word_clk, pair_clk, ser_thru;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expected tuple: {par_q, word_clk, pair_clk, ser_thru}
  logic [6:0] exp_q[$];
  string      tag_q[$];
  string      cur_tag = "R9 reset";

  // bench-side model state
  int         ph = 0;
  logic [3:0] hist = '0;     // hist[0] newest sampled bit
  logic [3:0] word_exp = '0;
  logic       seen_slip = 1'b0;
  int         slip_cd = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitslip_deser u_dut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .ser_a(ser_a), .ser_b(ser_b),
    .slip_async(slip_async), .wide_mode(wide_mode), .par_q(par_q),
    .word_clk(word_clk), .pair_clk(pair_clk), .ser_thru(ser_thru)
  );

  function automatic logic [15:0] lfsr_next(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // Drives one bit period and predicts the outputs after the coming edge.
  task automatic step(input logic r, input logic sel, input logic a, input logic b,
                      input logic slip, input logic wide);
    logic bit_in;
    logic skip;
    logic term;
    @(negedge clk);
    rst = r; src_sel = sel; ser_a = a; ser_b = b; slip_async = slip; wide_mode = wide;
    if (r) begin
      ph = 0; hist = '0; word_exp = '0; seen_slip = 1'b0; slip_cd = 0;
    end else begin
      bit_in = sel ? a : b;                         // R2
      skip = (slip_cd == 1);                        // R7: second edge after first high sample
      if (slip_cd > 0) slip_cd--;
      if (slip && !seen_slip) slip_cd = 2;          // R8: only a low-to-high change counts
      seen_slip = slip;
      hist = {hist[2:0], bit_in};
      if (!skip) begin
        term = wide ? (ph == 7) : ((ph % 4) == 3);
        if (term) word_exp = {hist[0], hist[1], hist[2], hist[3]};  // R1 oldest on bit 0
        ph = (ph + 1) % 8;
      end
    end
    exp_q.push_back({word_exp, ph[1], ph[2], hist[3]});
    tag_q.push_back(cur_tag);
  endtask

  task automatic run_stream(input int n, input logic sel, input logic wide, input logic indep);
    for (int i = 0; i < n; i++) begin
      lfsr = lfsr_next(lfsr);
      step(1'b0, sel, lfsr[0], indep ? lfsr[7] : ~lfsr[0], 1'b0, wide);
    end
  endtask

  task automatic slip_for(input int hi_len, input logic wide);
    for (int i = 0; i < hi_len; i++) begin
      lfsr = lfsr_next(lfsr);
      step(1'b0, 1'b1, lfsr[0], ~lfsr[0], 1'b1, wide);
    end
  endtask

  task automatic do_reset(input logic wide);
    cur_tag = "R9 reset";
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, wide);
  endtask

  // monitor: compares one expected tuple shortly after each rising edge
  initial begin
    logic [6:0] e;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (par_q !== e[6:3]) begin
          fails++;
          $display("FAIL %s R1/R3/R4/R5 par_q actual=%b expected=%b", t, par_q, e[6:3]);
        end
        checks++;
        if (word_clk !== e[2] || pair_clk !== e[1]) begin
          fails++;
          $display("FAIL %s R6 clocks actual=%b%b expected=%b%b", t, word_clk, pair_clk, e[2], e[1]);
        end
        checks++;
        if (ser_thru !== e[0]) begin
          fails++;
          $display("FAIL %s R10 ser_thru actual=%b expected=%b", t, ser_thru, e[0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(1'b0);
    cur_tag = "R3 narrow line A";           run_stream(40, 1'b1, 1'b0, 1'b0);
    cur_tag = "R2 select B";                run_stream(40, 1'b0, 1'b0, 1'b1);
    cur_tag = "R2 select A independent";    run_stream(24, 1'b1, 1'b0, 1'b1);
    cur_tag = "R7 short slip";              slip_for(2, 1'b0);
    run_stream(12, 1'b1, 1'b0, 1'b0);
    cur_tag = "R7 one-cycle slip";          slip_for(1, 1'b0);
    run_stream(10, 1'b1, 1'b0, 1'b0);
    cur_tag = "R7 back-to-back slips";      slip_for(2, 1'b0);
    run_stream(1, 1'b1, 1'b0, 1'b0);
    slip_for(2, 1'b0);
    run_stream(16, 1'b1, 1'b0, 1'b0);
    cur_tag = "R8 held slip";               slip_for(30, 1'b0);
    run_stream(16, 1'b1, 1'b0, 1'b0);
    cur_tag = "R9 mid-run reset";           do_reset(1'b1);
    cur_tag = "R4 wide framing";            run_stream(48, 1'b1, 1'b1, 1'b0);
    cur_tag = "R4 wide slip";               slip_for(3, 1'b1);
    run_stream(24, 1'b1, 1'b1, 1'b0);
    cur_tag = "R8 wide held slip";          slip_for(20, 1'b1);
    run_stream(24, 1'b0, 1'b1, 1'b1);
    do_reset(1'b0);
    cur_tag = "R5 constant ones hold";      for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    cur_tag = "R5 alternating";             for (int i = 0; i < 12; i++) step(1'b0, 1'b1, i[0], 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule